// File: doc/BRIEF.md
# Linear Burst DMA Bus-Tenure Controller

This block is the bus-master sequencer of a DMA engine that moves FIFO data between the engine and system memory on a 486-style local bus. When the FIFO side asks for service, the block raises a hold request. Once the grant arrives, it issues one word transfer per ready cycle and advances a word pointer. Transfers that start on an address aligned to the programmed linear burst length run as linear bursts. A pointer that starts unaligned is first brought to alignment with ordinary single cycles.

Each bus tenure is bounded by two limits: a cycle timer and a count of completed transfers. A preemption request acts the same way as either limit. None of these stop events cuts the tenure short in the middle of a burst. The burst always runs to its end, so the pointer is left on a legal burst start. If the event arrives late in a burst, one further complete burst follows before the hold request drops. A burst length that does not fit under the FIFO watermark is flagged as an error, and the block then falls back to single cycles only.

Top module: `lbd_tenure_ctrl`

## Requirements
- R1: During and after reset, hold_o, xfer_o and burst_o are low, err_o is low, and ptr_o is 0.
- R2: In the idle state, hold_o rises one cycle after req_i is high while hlda_i is low. xfer_o is never high unless hold_o and hlda_i are both high.
- R3: The burst length is L = 2**lbs_log2_i words. A tenure that starts at a pointer not a multiple of L issues single transfers (xfer_o high, burst_o low) until the pointer is a multiple of L. From there, transfers are burst transfers (burst_o high).
- R4: ptr_o increases by exactly one at each clock edge where xfer_o and rdy_i are both high, and is otherwise unchanged during a tenure. In the idle state, load_i loads start_ptr_i.
- R5: When burst_lim_i is nonzero, a stop event occurs during any transfer cycle in which the number of transfers already completed in this tenure is at least burst_lim_i. A value of 0 disables this limit.
- R6: A stop event during a burst transfer whose 0-based index i within the burst satisfies i + 4 < L lets the current burst finish, and then releases the bus (hold_o low). The pointer is then a multiple of L.
- R7: A stop event during a burst transfer with i + 4 >= L lets the current burst finish, then runs exactly one more complete burst of L transfers, and then releases the bus.
- R8: When timer_lim_i is nonzero, a stop event occurs once the number of transfer-state cycles in this tenure reaches timer_lim_i. The count restarts from zero at every new grant. A value of 0 disables the timer.
- R9: preempt_i high during a transfer cycle is a stop event, handled exactly like R6 and R7.
- R10: If 4 * L bytes exceeds wmark_i bytes, err_o is high and every transfer is a single transfer (burst_o stays low).
- R11: If no stop event is pending and req_i is low when a burst or single transfer completes, the bus is released after that transfer.
- R12: A stop event during a single transfer releases the bus after that transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | FIFO requests DMA service |
| hlda_i | input | 1 | Bus grant acknowledge |
| rdy_i | input | 1 | Current transfer completes this cycle |
| preempt_i | input | 1 | Another master needs the bus |
| load_i | input | 1 | Load start_ptr_i while idle |
| start_ptr_i | input | PTR_W | Start word address |
| lbs_log2_i | input | LBS_LOG2_W | log2 of the burst length in words |
| wmark_i | input | WM_W | FIFO watermark in bytes |
| burst_lim_i | input | CNT_W | Transfer limit per tenure, 0 = off |
| timer_lim_i | input | TMR_W | Cycle limit per tenure, 0 = off |
| hold_o | output | 1 | Bus hold request |
| xfer_o | output | 1 | Transfer cycle in progress |
| burst_o | output | 1 | Current transfer belongs to a linear burst |
| ptr_o | output | PTR_W | Current word pointer |
| err_o | output | 1 | Illegal burst length and watermark pair |

## Verification
Aligned starts with burst lengths of 1, 2, 4 and 8 words are run with the transfer limit set so that the stop lands on either side of the fourth-from-last transfer. The resulting transfer counts of one burst, two bursts or three bursts tell the early-stop rule apart from the late-stop rule. Unaligned starts separate the single-cycle alignment phase from bursting, with the stop placed inside that phase and again just after it. The timer, preemption, request withdrawal, the illegal watermark case and a back-to-back tenure without a reload each show which stop source triggered, and whether the per-tenure counters are cleared.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} lbd_st_e;
endpackage

// File: rtl/lbd_limit_ctr.sv
module lbd_limit_ctr #(
  parameter int TMR_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             done_i,
  input  logic [TMR_W-1:0] tmr_lim_i,
  input  logic [CNT_W-1:0] cnt_lim_i,
  output logic             exp_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (tick_i && !(&tmr_q)) tmr_q <= tmr_q + 1'b1;
      if (done_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign exp_o = ((tmr_lim_i != '0) && (tmr_q >= tmr_lim_i)) ||
                 ((cnt_lim_i != '0) && (cnt_q >= cnt_lim_i));
endmodule

// File: rtl/lbd_cfg_chk.sv
module lbd_cfg_chk #(
  parameter int LBS_LOG2_W     = 2,
  parameter int WM_W           = 8,
  parameter int BYTES_PER_XFER = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [LBS_LOG2_W-1:0] lbs_log2_i,
  input  logic [WM_W-1:0]       wmark_i,
  output logic [LBS_LOG2_W-1:0] lbs_log2_o,
  output logic                  err_o,
  output logic                  burst_ok_o
);
  logic [31:0] lbs_bytes;
  assign lbs_bytes = 32'(BYTES_PER_XFER) << lbs_log2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbs_log2_o <= '0;
      err_o      <= 1'b0;
    end else if (cap_i) begin
      lbs_log2_o <= lbs_log2_i;
      err_o      <= lbs_bytes > 32'(wmark_i);
    end
  end

  assign burst_ok_o = !err_o;
endmodule

// File: rtl/lbd_tenure_ctrl.sv
module lbd_tenure_ctrl
  import lbd_pkg::*;
#(
  parameter int PTR_W          = 16,
  parameter int LBS_LOG2_W     = 2,
  parameter int WM_W           = 8,
  parameter int CNT_W          = 8,
  parameter int TMR_W          = 16,
  parameter int BYTES_PER_XFER = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  hlda_i,
  input  logic                  rdy_i,
  input  logic                  preempt_i,
  input  logic                  load_i,
  input  logic [PTR_W-1:0]      start_ptr_i,
  input  logic [LBS_LOG2_W-1:0] lbs_log2_i,
  input  logic [WM_W-1:0]       wmark_i,
  input  logic [CNT_W-1:0]      burst_lim_i,
  input  logic [TMR_W-1:0]      timer_lim_i,
  output logic                  hold_o,
  output logic                  xfer_o,
  output logic                  burst_o,
  output logic [PTR_W-1:0]      ptr_o,
  output logic                  err_o
);
  localparam int IDX_W = (1 << LBS_LOG2_W) - 1;
  localparam int LBS_W = IDX_W + 2;

  lbd_st_e               st_q;
  logic [PTR_W-1:0]      ptr_q, nxt_ptr, amask;
  logic [IDX_W-1:0]      bidx_q, lbs_m1;
  logic [LBS_W-1:0]      lbs_len;
  logic [LBS_LOG2_W-1:0] lbs_q;
  logic inb_q, stop_q, extra_q, burst_ok, lim_exp;
  logic done, stop_now, late_evt, extra_now, eob, al_cur, al_nxt, release_now;

  lbd_cfg_chk #(
    .LBS_LOG2_W(LBS_LOG2_W), .WM_W(WM_W), .BYTES_PER_XFER(BYTES_PER_XFER)
  ) u_cfg (
    .clk_i, .rst_ni,
    .cap_i      (st_q == ST_IDLE),
    .lbs_log2_i,
    .wmark_i,
    .lbs_log2_o (lbs_q),
    .err_o,
    .burst_ok_o (burst_ok)
  );

  lbd_limit_ctr #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_lim (
    .clk_i, .rst_ni,
    .clr_i     (st_q == ST_IDLE),
    .tick_i    (st_q == ST_XFER),
    .done_i    (done),
    .tmr_lim_i (timer_lim_i),
    .cnt_lim_i (burst_lim_i),
    .exp_o     (lim_exp)
  );

  assign lbs_len = LBS_W'(1) << lbs_q;
  assign lbs_m1  = IDX_W'(lbs_len - LBS_W'(1));
  assign amask   = PTR_W'(lbs_len - LBS_W'(1));
  assign nxt_ptr = ptr_q + 1'b1;
  assign al_cur  = (ptr_q & amask) == '0;
  assign al_nxt  = (nxt_ptr & amask) == '0;

  assign done      = (st_q == ST_XFER) && rdy_i;
  assign stop_now  = stop_q || preempt_i || lim_exp;
  // stop late in a burst: within the last four transfers
  assign late_evt  = inb_q && ((LBS_W'(bidx_q) + LBS_W'(4)) >= lbs_len);
  assign extra_now = stop_q ? extra_q : late_evt;
  assign eob       = !inb_q || (bidx_q == lbs_m1);
  assign release_now = (stop_now && !extra_now) || (!stop_now && !req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      bidx_q  <= '0;
      inb_q   <= 1'b0;
      stop_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (load_i) ptr_q <= start_ptr_i;
          if (req_i && !hlda_i) st_q <= ST_REQ;
        end
        ST_REQ: begin
          if (hlda_i) begin
            st_q    <= ST_XFER;
            inb_q   <= burst_ok && al_cur;
            bidx_q  <= '0;
            stop_q  <= 1'b0;
            extra_q <= 1'b0;
          end
        end
        ST_XFER: begin
          if (done) begin
            ptr_q <= nxt_ptr;
            if (eob) begin
              bidx_q  <= '0;
              stop_q  <= stop_now;
              extra_q <= 1'b0;
              if (release_now) begin
                st_q  <= ST_IDLE;
                inb_q <= 1'b0;
              end else begin
                inb_q <= burst_ok && al_nxt;
              end
            end else begin
              bidx_q  <= bidx_q + 1'b1;
              stop_q  <= stop_now;
              extra_q <= extra_now;
            end
          end else begin
            stop_q  <= stop_now;
            extra_q <= extra_now;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_o  = st_q != ST_IDLE;
  assign xfer_o  = st_q == ST_XFER;
  assign burst_o = xfer_o && inb_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/lbd_tenure_ctrl_chk.sv
module lbd_tenure_ctrl_chk #(
  parameter int PTR_W      = 16,
  parameter int LBS_LOG2_W = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  hold_o,
  input logic                  hlda_i,
  input logic                  xfer_o,
  input logic                  burst_o,
  input logic                  rdy_i,
  input logic                  err_o,
  input logic [PTR_W-1:0]      ptr_o,
  input logic [LBS_LOG2_W-1:0] lbs_q
);
  logic [PTR_W-1:0] amask;
  assign amask = PTR_W'((32'd1 << lbs_q) - 32'd1);

  assert_xfer_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (hold_o && hlda_i));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && rdy_i) |=> (ptr_o == $past(ptr_o) + 1'b1));

  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !(xfer_o && rdy_i)) |=> $stable(ptr_o));

  assert_aligned_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_o) && $past(burst_o)) |-> ((ptr_o & amask) == '0));

  assert_no_burst_on_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !burst_o);
endmodule

bind lbd_tenure_ctrl lbd_tenure_ctrl_chk #(
  .PTR_W(PTR_W), .LBS_LOG2_W(LBS_LOG2_W)
) u_chk (
  .clk_i, .rst_ni, .hold_o, .hlda_i, .xfer_o, .burst_o, .rdy_i, .err_o, .ptr_o, .lbs_q
);

// File: tb/lbd_tenure_ctrl_test.sv
`timescale 1ns/1ps
module lbd_tenure_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, hlda = 0, rdy = 1, preempt = 0, load = 0;
  logic [15:0] start_ptr = 0, tlim = 0;
  logic [1:0]  lbs = 0;
  logic [7:0]  wm = 0, blim = 0;
  logic hold, xfer, burst, err;
  logic [15:0] ptr;
  int checks = 0, errors = 0;
  bit  done_flag = 0;

  always #2 clk = ~clk;

  lbd_tenure_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hlda_i(hlda), .rdy_i(rdy),
    .preempt_i(preempt), .load_i(load), .start_ptr_i(start_ptr),
    .lbs_log2_i(lbs), .wmark_i(wm), .burst_lim_i(blim), .timer_lim_i(tlim),
    .hold_o(hold), .xfer_o(xfer), .burst_o(burst), .ptr_o(ptr), .err_o(err)
  );

  // arbiter model: grant follows hold half a cycle later
  initial forever begin
    @(negedge clk);
    hlda = hold;
  end

  typedef struct packed {
    logic [15:0] st; logic [1:0] l; logic [7:0] w; logic [7:0] b; logic [15:0] t;
    logic [7:0] n; logic [7:0] nb; logic [15:0] p; logic e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'd0, 2'd3, 8'd32, 8'd3,  16'd0, 8'd8,  8'd8,  16'd8,  1'b0}, // R5 R6 early stop
    '{16'd0, 2'd3, 8'd32, 8'd4,  16'd0, 8'd16, 8'd16, 16'd16, 1'b0}, // R7 idx 4 of 8
    '{16'd0, 2'd3, 8'd32, 8'd11, 16'd0, 8'd16, 8'd16, 16'd16, 1'b0}, // R6 second burst idx 3
    '{16'd0, 2'd3, 8'd32, 8'd12, 16'd0, 8'd24, 8'd24, 16'd24, 1'b0}, // R7 second burst idx 4
    '{16'd5, 2'd3, 8'd32, 8'd2,  16'd0, 8'd3,  8'd0,  16'd8,  1'b0}, // R3 R12 stop in singles
    '{16'd5, 2'd3, 8'd32, 8'd4,  16'd0, 8'd11, 8'd8,  16'd16, 1'b0}, // R3 align then burst
    '{16'd0, 2'd3, 8'd16, 8'd5,  16'd0, 8'd6,  8'd0,  16'd6,  1'b1}, // R10 illegal pair
    '{16'd0, 2'd2, 8'd16, 8'd2,  16'd0, 8'd8,  8'd8,  16'd8,  1'b0}, // R7 L=4
    '{16'd0, 2'd0, 8'd4,  8'd3,  16'd0, 8'd5,  8'd5,  16'd5,  1'b0}, // R7 L=1
    '{16'd0, 2'd3, 8'd32, 8'd0,  16'd3, 8'd8,  8'd8,  16'd8,  1'b0}, // R8 timer early
    '{16'd0, 2'd3, 8'd32, 8'd0,  16'd4, 8'd16, 8'd16, 16'd16, 1'b0}, // R8 timer late
    '{16'd0, 2'd1, 8'd8,  8'd3,  16'd0, 8'd6,  8'd6,  16'd6,  1'b0}  // R7 L=2
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic do_load, input logic [15:0] s, input logic [1:0] l,
                     input logic [7:0] w, input logic [7:0] b, input logic [15:0] t,
                     input int pre_at, input int drop_at,
                     output int n, output int nb, output int viol);
    bit granted = 0;
    n = 0; nb = 0; viol = 0;
    @(negedge clk);
    start_ptr = s; lbs = l; wm = w; blim = b; tlim = t; load = do_load;
    @(negedge clk);
    load = 0; req = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (xfer && !(hold && hlda)) viol++;
      if (xfer) granted = 1;
      if (granted && !hold) break;
      if (xfer && rdy) begin
        n++;
        if (burst) nb++;
      end
      if (pre_at != 0 && n == pre_at) preempt = 1;
      if (drop_at != 0 && n == drop_at) req = 0;
      if (i == 999) chk("R2 tenure watchdog", 1, 0);
    end
    req = 0; preempt = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, nb, v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hold", hold, 0); chk("R1 xfer", xfer, 0); chk("R1 burst", burst, 0);
    chk("R1 err", err, 0);   chk("R1 ptr", ptr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R2 no hold without req", hold, 0);

    for (int k = 0; k < NV; k++) begin
      run(1'b1, VECS[k].st, VECS[k].l, VECS[k].w, VECS[k].b, VECS[k].t, 0, 0, n, nb, v);
      chk($sformatf("vec %0d transfers", k), n, VECS[k].n);
      chk($sformatf("vec %0d burst transfers", k), nb, VECS[k].nb);
      chk($sformatf("R4 vec %0d ptr", k), ptr, VECS[k].p);
      chk($sformatf("R10 vec %0d err", k), err, VECS[k].e);
      chk($sformatf("R2 vec %0d grant order", k), v, 0);
    end

    // R9 preempt early in burst
    run(1'b1, 16'd0, 2'd3, 8'd32, 8'd0, 16'd0, 2, 0, n, nb, v);
    chk("R9 preempt idx1 transfers", n, 8);
    chk("R9 preempt idx1 ptr", ptr, 8);
    // R9 preempt late in burst
    run(1'b1, 16'd0, 2'd3, 8'd32, 8'd0, 16'd0, 6, 0, n, nb, v);
    chk("R9 preempt idx5 transfers", n, 16);
    // R11 request withdrawn mid burst
    run(1'b1, 16'd0, 2'd3, 8'd32, 8'd0, 16'd0, 0, 3, n, nb, v);
    chk("R11 req drop transfers", n, 8);
    chk("R11 req drop ptr", ptr, 8);
    // R11 request withdrawn during singles
    run(1'b1, 16'd3, 2'd3, 8'd32, 8'd0, 16'd0, 0, 1, n, nb, v);
    chk("R11 req drop single transfers", n, 1);
    chk("R11 req drop single ptr", ptr, 4);
    // R8 timer cleared on each tenure, pointer carried over
    run(1'b1, 16'd8, 2'd3, 8'd32, 8'd0, 16'd3, 0, 0, n, nb, v);
    chk("R8 first tenure transfers", n, 8);
    run(1'b0, 16'd0, 2'd3, 8'd32, 8'd0, 16'd3, 0, 0, n, nb, v);
    chk("R8 second tenure transfers", n, 8);
    chk("R4 second tenure ptr", ptr, 24);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule